// File: doc/BRIEF.md
# ADC Offset and Gain Calibration Controller

This block sits between the decimation filter of an oversampling converter and its output data register. Every filtered raw sample has a stored offset coefficient subtracted from it, and the difference is then multiplied by a stored gain coefficient. The arithmetic runs on a wide internal path and is saturated to either a 24-bit or a 16-bit result code, as a control bit selects. The host can write both coefficients directly and read them back at any time.

Writing the self-calibration mode code starts a two-point calibration sequence. The block resets the filter and converts the shorted-input (zero-scale) node. That reading becomes the new offset. The block then switches its input select to the reference node, resets the filter again and converts the reference. A sequential restoring divider divides the ideal reference code by the measured span (reference minus zero) to produce the new gain. The active-low ready line is held high for the whole sequence and falls once the divider has finished. A falling edge on the sync input also resets the filter. If that edge arrives during a calibration step, the step's settling count starts again.

Top module: `adc_cal_core`

## Requirements
- R1: After reset, result is 0, dataRdyN is 1, filterRst is 0, refSel is 0, offsetCoef is 0 and gainCoef is 2^20, which means unity gain with 20 fractional bits.
- R2: In normal operation, a sample presented with sampleValid at a clock edge produces floor(((sampleRaw − offsetCoef) × gainCoef) / 2^20) in result after that edge, and dataRdyN goes to 0. The subtraction happens before the multiplication.
- R3: The width bit is latched on any ctrlWe write and is 1 after reset. With the bit at 1, the result is the full 24-bit code. With it at 0, the corrected value is shifted arithmetically right by 8 and placed as a 16-bit code, sign-extended to 24 bits.
- R4: Corrected values saturate to the selected width: 8388607 and −8388608 for 24-bit, 32767 and −32768 for 16-bit.
- R5: offWe and gainWe load offsetCoef and gainCoef from the host, and the next sample is corrected with the written values.
- R6: A ctrlWe write with ctrlMode equal to 3'b001 starts calibration. filterRst is 1 for exactly one cycle after that edge, and dataRdyN is 1 from that edge until calibration completes. Any other mode value starts nothing and only updates the width bit.
- R7: In each calibration step, the first 3 valid samples are discarded. The 4th is the measurement. The zero-scale measurement is stored as offsetCoef. At that edge refSel goes to 1 and filterRst pulses.
- R8: After the reference measurement, refSel returns to 0. When the divider finishes, gainCoef becomes min(floor(2^42 / span), 2^24 − 1), where span is the reference reading minus the zero reading. dataRdyN then falls to 0.
- R9: A span of zero or less leaves gainCoef unchanged. The offset is still updated, and calibration still completes.
- R10: result does not change while calibration is running. The first valid sample after completion updates it with the new coefficients.
- R11: A falling edge on syncN makes filterRst 1 for one cycle after the edge where it is seen. During a calibration step, the edge restarts that step's count of discarded samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleValid | input | 1 | Raw sample strobe from the filter |
| sampleRaw | input | 24 | Signed raw filtered sample |
| ctrlWe | input | 1 | Control register write strobe |
| ctrlMode | input | 3 | Mode field; 3'b001 requests self-calibration |
| ctrlWide | input | 1 | Width select: 1 gives a 24-bit result, 0 a 16-bit result |
| syncN | input | 1 | Sync input; a falling edge resets the filter |
| offWe | input | 1 | Host write strobe for the offset coefficient |
| offWrData | input | 24 | Signed offset value to write |
| gainWe | input | 1 | Host write strobe for the gain coefficient |
| gainWrData | input | 24 | Unsigned gain value with 20 fractional bits |
| result | output | 24 | Corrected, saturated output code |
| dataRdyN | output | 1 | Active-low data ready; high during calibration |
| filterRst | output | 1 | One-cycle filter reset pulse |
| refSel | output | 1 | Input select: 0 for the zero-scale node, 1 for the reference node |
| offsetCoef | output | 24 | Current offset coefficient |
| gainCoef | output | 24 | Current gain coefficient |

## Verification
The hardest case to reach is a sync edge that lands in the middle of a calibration step after some samples have already been discarded. Only the value captured as the offset reveals whether the settling count restarted. The bench feeds two samples, drops syncN, and then feeds a run of distinct sample values. A design that fails to restart captures a different value than one that restarts. A second hard case is a span so small that the quotient exceeds the gain register. The same sequence ends with a reference reading only three codes above zero, which must produce the clamped all-ones gain.

// File: rtl/calib_pkg.sv
package calib_pkg;

  typedef enum logic [1:0] {
    CAL_IDLE,
    CAL_ZERO,
    CAL_REF,
    CAL_DIV
  } calState_e;

  // strobes from the sequencer to the arithmetic side
  typedef struct packed {
    logic update;    // load a corrected result
    logic capZero;   // zero-scale measurement taken
    logic capRef;    // reference measurement taken
    logic divStart;  // launch the span divider
    logic finish;    // divider finished, commit gain
    logic calRun;    // calibration in progress
  } calStrb_t;

  localparam logic [2:0] MODE_SELFCAL = 3'b001;

endpackage

// File: rtl/calib_div.sv
module calib_div #(
  parameter int DVD_W = 43,
  parameter int DVS_W = 25
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [DVD_W-1:0] dividend,
  input  logic [DVS_W-1:0] divisor,
  output logic [DVD_W-1:0] quotient,
  output logic             done
);
  localparam int CNT_W = $clog2(DVD_W + 1);

  logic [DVD_W-1:0] shQ;
  logic [DVS_W-1:0] remQ;
  logic [DVS_W-1:0] dvsQ;
  logic [CNT_W-1:0] cntQ;
  logic             busyQ;
  logic             doneQ;
  logic [DVS_W:0]   trial;
  logic [DVS_W:0]   trialSub;
  logic             fits;

  assign trial    = {remQ, shQ[DVD_W-1]};
  assign fits     = trial >= {1'b0, dvsQ};
  assign trialSub = trial - {1'b0, dvsQ};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shQ   <= '0;
      remQ  <= '0;
      dvsQ  <= '0;
      cntQ  <= '0;
      busyQ <= 1'b0;
      doneQ <= 1'b0;
    end else if (start) begin
      shQ   <= dividend;
      remQ  <= '0;
      dvsQ  <= divisor;
      cntQ  <= CNT_W'(DVD_W);
      busyQ <= 1'b1;
      doneQ <= 1'b0;
    end else if (busyQ) begin
      remQ <= fits ? trialSub[DVS_W-1:0] : trial[DVS_W-1:0];
      shQ  <= {shQ[DVD_W-2:0], fits};
      cntQ <= cntQ - 1'b1;
      if (cntQ == CNT_W'(1)) begin
        busyQ <= 1'b0;
        doneQ <= 1'b1;
      end
    end else begin
      doneQ <= 1'b0;
    end
  end

  assign quotient = shQ;
  assign done     = doneQ;

  // R8
  div_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    start |=> busyQ);

endmodule

// File: rtl/calib_ctrl.sv
module calib_ctrl
  import calib_pkg::*;
#(
  parameter int SETTLE = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sampleValid,
  input  logic       ctrlWe,
  input  logic [2:0] ctrlMode,
  input  logic       ctrlWide,
  input  logic       syncN,
  input  logic       divDone,
  output calStrb_t   strb,
  output logic       wideQ,
  output logic       dataRdyN,
  output logic       filterRst,
  output logic       refSel
);
  localparam int CNT_W = $clog2(SETTLE + 2);

  calState_e        stateQ;
  logic [CNT_W-1:0] settleCnt;
  logic             syncPrev;
  logic             syncFall;
  logic             calCmd;
  logic             inStep;
  logic             settled;
  logic             take;
  logic             divGo;

  assign syncFall = syncPrev & ~syncN;
  assign calCmd   = ctrlWe && (ctrlMode == MODE_SELFCAL);
  assign inStep   = (stateQ == CAL_ZERO) || (stateQ == CAL_REF);
  assign settled  = settleCnt == CNT_W'(SETTLE);
  assign take     = inStep && sampleValid && !syncFall && !calCmd && settled;

  always_comb begin
    strb          = '0;
    strb.update   = (stateQ == CAL_IDLE) && sampleValid && !calCmd;
    strb.capZero  = take && (stateQ == CAL_ZERO);
    strb.capRef   = take && (stateQ == CAL_REF);
    strb.divStart = divGo;
    strb.finish   = (stateQ == CAL_DIV) && divDone && !calCmd;
    strb.calRun   = stateQ != CAL_IDLE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ    <= CAL_IDLE;
      settleCnt <= '0;
      syncPrev  <= 1'b1;
      divGo     <= 1'b0;
      filterRst <= 1'b0;
      dataRdyN  <= 1'b1;
      wideQ     <= 1'b1;
    end else begin
      syncPrev  <= syncN;
      divGo     <= strb.capRef;
      filterRst <= calCmd | syncFall | strb.capZero;
      if (ctrlWe) wideQ <= ctrlWide;

      if (calCmd) dataRdyN <= 1'b1;
      else if (strb.finish || strb.update) dataRdyN <= 1'b0;

      if (calCmd) begin
        stateQ    <= CAL_ZERO;
        settleCnt <= '0;
      end else begin
        unique case (stateQ)
          CAL_ZERO, CAL_REF: begin
            if (syncFall) settleCnt <= '0;
            else if (sampleValid) begin
              if (settled) begin
                settleCnt <= '0;
                stateQ    <= (stateQ == CAL_ZERO) ? CAL_REF : CAL_DIV;
              end else begin
                settleCnt <= settleCnt + 1'b1;
              end
            end
          end
          CAL_DIV:  if (divDone) stateQ <= CAL_IDLE;
          default:  stateQ <= CAL_IDLE;
        endcase
      end
    end
  end

  assign refSel = stateQ == CAL_REF;

  // R6
  cal_ready_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.calRun |-> dataRdyN);

  // R11
  sync_filter_rst_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(syncN) |=> filterRst);

  // R7
  zero_to_ref_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.capZero |=> (refSel && filterRst));

endmodule

// File: rtl/calib_dp.sv
module calib_dp
  import calib_pkg::*;
#(
  parameter int RAW_W     = 24,
  parameter int NARROW_W  = 16,
  parameter int GAIN_W    = 24,
  parameter int GAIN_FRAC = 20,
  parameter int ACC_W     = 33,
  parameter int DVD_W     = 43
) (
  input  logic              clk,
  input  logic              rstN,
  input  calStrb_t          strb,
  input  logic              wide,
  input  logic [RAW_W-1:0]  sampleRaw,
  input  logic              offWe,
  input  logic [RAW_W-1:0]  offWrData,
  input  logic              gainWe,
  input  logic [GAIN_W-1:0] gainWrData,
  input  logic [DVD_W-1:0]  divQuot,
  output logic [RAW_W:0]    divisor,
  output logic [RAW_W-1:0]  result,
  output logic [RAW_W-1:0]  offsetCoef,
  output logic [GAIN_W-1:0] gainCoef
);
  localparam int PROD_W   = RAW_W + GAIN_W + 2;
  localparam int NAR_SH   = RAW_W - NARROW_W;
  localparam logic [GAIN_W-1:0] GAIN_ONE = {{(GAIN_W-1){1'b0}}, 1'b1} << GAIN_FRAC;

  logic [RAW_W-1:0]         offsetQ, zeroQ, refQ, resultQ;
  logic [GAIN_W-1:0]        gainQ, gainCalc;
  logic signed [RAW_W:0]    diff, span;
  logic signed [PROD_W-1:0] diffX, gainX, prod, prodSh;
  logic signed [ACC_W-1:0]  acc, accNar, pick, lim, wideMax, wideMin, narMax, narMin;
  logic signed [ACC_W-1:0]  hiLim, loLim;
  logic                     spanPos;

  assign wideMax = $signed({{(ACC_W-RAW_W+1){1'b0}}, {(RAW_W-1){1'b1}}});
  assign wideMin = $signed({{(ACC_W-RAW_W+1){1'b1}}, {(RAW_W-1){1'b0}}});
  assign narMax  = $signed({{(ACC_W-NARROW_W+1){1'b0}}, {(NARROW_W-1){1'b1}}});
  assign narMin  = $signed({{(ACC_W-NARROW_W+1){1'b1}}, {(NARROW_W-1){1'b0}}});

  // offset removed first, then the gain multiply
  assign diff   = $signed({sampleRaw[RAW_W-1], sampleRaw}) - $signed({offsetQ[RAW_W-1], offsetQ});
  assign diffX  = $signed({{(PROD_W-RAW_W-1){diff[RAW_W]}}, diff});
  assign gainX  = $signed({{(PROD_W-GAIN_W){1'b0}}, gainQ});
  assign prod   = diffX * gainX;
  assign prodSh = prod >>> GAIN_FRAC;
  assign acc    = prodSh[ACC_W-1:0];
  assign accNar = acc >>> NAR_SH;

  always_comb begin
    pick  = wide ? acc : accNar;
    hiLim = wide ? wideMax : narMax;
    loLim = wide ? wideMin : narMin;
    if (pick > hiLim)      lim = hiLim;
    else if (pick < loLim) lim = loLim;
    else                   lim = pick;
  end

  // span and divider operand
  assign span    = $signed({refQ[RAW_W-1], refQ}) - $signed({zeroQ[RAW_W-1], zeroQ});
  assign spanPos = !span[RAW_W] && (span != '0);
  assign divisor = span;

  generate
    if (DVD_W > GAIN_W) begin : g_clamp
      assign gainCalc = (|divQuot[DVD_W-1:GAIN_W]) ? '1 : divQuot[GAIN_W-1:0];
    end else begin : g_fit
      assign gainCalc = GAIN_W'(divQuot);
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      offsetQ <= '0;
      zeroQ   <= '0;
      refQ    <= '0;
      gainQ   <= GAIN_ONE;
      resultQ <= '0;
    end else begin
      if (strb.capZero) begin
        zeroQ   <= sampleRaw;
        offsetQ <= sampleRaw;
      end else if (offWe) begin
        offsetQ <= offWrData;
      end
      if (strb.capRef) refQ <= sampleRaw;
      if (strb.finish && spanPos) gainQ <= gainCalc;
      else if (gainWe)            gainQ <= gainWrData;
      if (strb.update) resultQ <= lim[RAW_W-1:0];
    end
  end

  assign result     = resultQ;
  assign offsetCoef = offsetQ;
  assign gainCoef   = gainQ;

  // R10
  cal_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.calRun |=> $stable(resultQ));

  // R3
  narrow_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.update && !wide) |=> ((&resultQ[RAW_W-1:NARROW_W-1]) || !(|resultQ[RAW_W-1:NARROW_W-1])));

  // R9
  zero_span_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.finish && !spanPos && !gainWe) |=> $stable(gainQ));

endmodule

// File: rtl/adc_cal_core.sv
module adc_cal_core
  import calib_pkg::*;
#(
  parameter int RAW_W     = 24,
  parameter int NARROW_W  = 16,
  parameter int GAIN_W    = 24,
  parameter int GAIN_FRAC = 20,
  parameter int ACC_W     = 33,
  parameter int FULL_LOG2 = 22,
  parameter int SETTLE    = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleValid,
  input  logic [RAW_W-1:0]  sampleRaw,
  input  logic              ctrlWe,
  input  logic [2:0]        ctrlMode,
  input  logic              ctrlWide,
  input  logic              syncN,
  input  logic              offWe,
  input  logic [RAW_W-1:0]  offWrData,
  input  logic              gainWe,
  input  logic [GAIN_W-1:0] gainWrData,
  output logic [RAW_W-1:0]  result,
  output logic              dataRdyN,
  output logic              filterRst,
  output logic              refSel,
  output logic [RAW_W-1:0]  offsetCoef,
  output logic [GAIN_W-1:0] gainCoef
);
  localparam int DVD_W = FULL_LOG2 + GAIN_FRAC + 1;
  localparam logic [DVD_W-1:0] DIVIDEND = {1'b1, {(DVD_W-1){1'b0}}};

  calStrb_t         strb;
  logic             wide;
  logic             divDone;
  logic [DVD_W-1:0] divQuot;
  logic [RAW_W:0]   divisor;

  calib_ctrl #(.SETTLE(SETTLE)) u_ctrl (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .ctrlWe(ctrlWe),
    .ctrlMode(ctrlMode), .ctrlWide(ctrlWide), .syncN(syncN), .divDone(divDone),
    .strb(strb), .wideQ(wide), .dataRdyN(dataRdyN), .filterRst(filterRst),
    .refSel(refSel)
  );

  calib_dp #(
    .RAW_W(RAW_W), .NARROW_W(NARROW_W), .GAIN_W(GAIN_W),
    .GAIN_FRAC(GAIN_FRAC), .ACC_W(ACC_W), .DVD_W(DVD_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wide(wide), .sampleRaw(sampleRaw),
    .offWe(offWe), .offWrData(offWrData), .gainWe(gainWe), .gainWrData(gainWrData),
    .divQuot(divQuot), .divisor(divisor), .result(result),
    .offsetCoef(offsetCoef), .gainCoef(gainCoef)
  );

  calib_div #(.DVD_W(DVD_W), .DVS_W(RAW_W + 1)) u_div (
    .clk(clk), .rstN(rstN), .start(strb.divStart), .dividend(DIVIDEND),
    .divisor(divisor), .quotient(divQuot), .done(divDone)
  );

endmodule

// File: tb/sim_adc_cal_core.sv
module sim_adc_cal_core;
  localparam longint GMAX = 64'd16777215;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sampleValid = 1'b0;
  logic [23:0] sampleRaw = '0;
  logic        ctrlWe = 1'b0;
  logic [2:0]  ctrlMode = '0;
  logic        ctrlWide = 1'b1;
  logic        syncN = 1'b1;
  logic        offWe = 1'b0;
  logic [23:0] offWrData = '0;
  logic        gainWe = 1'b0;
  logic [23:0] gainWrData = '0;
  logic [23:0] result;
  logic        dataRdyN, filterRst, refSel;
  logic [23:0] offsetCoef, gainCoef;

  int nChecks = 0;
  int nFails  = 0;

  adc_cal_core u0 (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleRaw(sampleRaw),
    .ctrlWe(ctrlWe), .ctrlMode(ctrlMode), .ctrlWide(ctrlWide), .syncN(syncN),
    .offWe(offWe), .offWrData(offWrData), .gainWe(gainWe), .gainWrData(gainWrData),
    .result(result), .dataRdyN(dataRdyN), .filterRst(filterRst), .refSel(refSel),
    .offsetCoef(offsetCoef), .gainCoef(gainCoef)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input longint act, input longint exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint sres();
    return longint'($signed(result));
  endfunction

  function automatic longint expCorr(longint raw, longint off, longint gain, bit wide);
    longint c;
    c = ((raw - off) * gain) >>> 20;
    if (wide) begin
      if (c > 8388607) c = 8388607;
      if (c < -8388608) c = -8388608;
    end else begin
      c = c >>> 8;
      if (c > 32767) c = 32767;
      if (c < -32768) c = -32768;
    end
    return c;
  endfunction

  task automatic drvSample(input longint v);
    sampleValid = 1'b1;
    sampleRaw   = v[23:0];
    @(negedge clk);
    sampleValid = 1'b0;
  endtask

  task automatic ctrlWrite(input logic [2:0] mode, input logic wide);
    ctrlWe = 1'b1; ctrlMode = mode; ctrlWide = wide;
    @(negedge clk);
    ctrlWe = 1'b0;
  endtask

  task automatic hostWrite(input longint off, input longint gain);
    offWe = 1'b1; offWrData = off[23:0];
    gainWe = 1'b1; gainWrData = gain[23:0];
    @(negedge clk);
    offWe = 1'b0; gainWe = 1'b0;
  endtask

  task automatic waitCal(input longint held);
    for (int i = 0; i < 300; i++) begin
      if (!dataRdyN) break;
      if (sres() != held) chk("R10 result held in divider wait", sres(), held);
      @(negedge clk);
    end
    chk("R8 ready falls at completion", dataRdyN, 0);
  endtask

  task automatic testReset();
    chk("R1 result", sres(), 0);
    chk("R1 dataRdyN", dataRdyN, 1);
    chk("R1 filterRst", filterRst, 0);
    chk("R1 refSel", refSel, 0);
    chk("R1 offset", longint'($signed(offsetCoef)), 0);
    chk("R1 gain", longint'(gainCoef), 1048576);
  endtask

  task automatic testNormal();
    drvSample(12345);
    chk("R2 unity positive", sres(), 12345);
    chk("R2 ready low", dataRdyN, 0);
    drvSample(-7);
    chk("R2 unity negative", sres(), -7);
  endtask

  task automatic testHostWrite();
    hostWrite(-200, 1572864);
    chk("R5 offset readback", longint'($signed(offsetCoef)), -200);
    chk("R5 gain readback", longint'(gainCoef), 1572864);
    drvSample(1000);
    chk("R5 R2 offset then gain", sres(), expCorr(1000, -200, 1572864, 1));
  endtask

  task automatic testSaturate();
    hostWrite(0, 8388608);
    drvSample(2097157);
    chk("R4 wide max clamp", sres(), 8388607);
    drvSample(-2097157);
    chk("R4 wide min clamp", sres(), -8388608);
    ctrlWrite(3'b010, 1'b0);
    chk("R6 other mode no filter reset", filterRst, 0);
    chk("R6 other mode no calibration", refSel, 0);
    drvSample(2097152);
    chk("R4 narrow max clamp", sres(), 32767);
    drvSample(-2097152);
    chk("R4 narrow min clamp", sres(), -32768);
    hostWrite(0, 1048576);
    drvSample(-1000);
    chk("R3 narrow arithmetic shift", sres(), expCorr(-1000, 0, 1048576, 0));
    drvSample(200000);
    chk("R3 narrow value", sres(), 781);
    ctrlWrite(3'b000, 1'b1);
  endtask

  task automatic testCalMain();
    longint held;
    hostWrite(0, 1048576);
    drvSample(4321);
    held = sres();
    ctrlWrite(3'b001, 1'b1);
    chk("R6 filter reset on command", filterRst, 1);
    chk("R6 ready high", dataRdyN, 1);
    @(negedge clk);
    chk("R6 filter reset one cycle", filterRst, 0);
    drvSample(999); drvSample(998); drvSample(997);
    chk("R7 settling samples discarded", longint'($signed(offsetCoef)), 0);
    chk("R10 result held during zero step", sres(), held);
    chk("R7 still on zero node", refSel, 0);
    drvSample(1000);
    chk("R7 offset from zero reading", longint'($signed(offsetCoef)), 1000);
    chk("R7 reference selected", refSel, 1);
    chk("R7 filter reset at step change", filterRst, 1);
    drvSample(5); drvSample(6); drvSample(7);
    chk("R10 result held during ref step", sres(), held);
    drvSample(1000 + 2097152);
    chk("R8 reference deselected", refSel, 0);
    chk("R8 ready still high", dataRdyN, 1);
    waitCal(held);
    chk("R8 gain from span", longint'(gainCoef), 2097152);
    drvSample(101000);
    chk("R10 first update after calibration", sres(), 200000);
  endtask

  task automatic testZeroSpan();
    longint held;
    held = sres();
    ctrlWrite(3'b001, 1'b1);
    drvSample(1); drvSample(2); drvSample(3);
    drvSample(500);
    drvSample(1); drvSample(2); drvSample(3);
    drvSample(500);
    waitCal(held);
    chk("R9 zero span keeps gain", longint'(gainCoef), 2097152);
    chk("R9 offset still updated", longint'($signed(offsetCoef)), 500);
  endtask

  task automatic testSync();
    longint held;
    syncN = 1'b0;
    @(negedge clk);
    chk("R11 filter reset on sync fall", filterRst, 1);
    syncN = 1'b1;
    @(negedge clk);
    chk("R11 pulse is one cycle", filterRst, 0);
    held = sres();
    ctrlWrite(3'b001, 1'b1);
    drvSample(10); drvSample(11);
    syncN = 1'b0;
    @(negedge clk);
    chk("R11 filter reset during calibration", filterRst, 1);
    syncN = 1'b1;
    drvSample(20); drvSample(21); drvSample(22);
    chk("R11 count restarted", refSel, 0);
    drvSample(2000);
    chk("R11 R7 offset after restart", longint'($signed(offsetCoef)), 2000);
    drvSample(1); drvSample(2); drvSample(3);
    drvSample(2003);
    waitCal(held);
    chk("R8 gain clamps to max", longint'(gainCoef), GMAX);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testNormal();
    testHostWrite();
    testSaturate();
    testCalMain();
    testZeroSpan();
    testSync();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule